// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a down-counting supervisor that asks for a system reset when software reloads it too late or too early. The counter steps down by one on every prescaled tick while the watchdog is armed. If the counter's top bit falls from one to zero, the refresh came too late, and a reset is requested. A reload that arrives while the counter still sits above a programmed window value came too early, and a reset is also requested.

Software writes the counter through a single write port. The low bits of that word give the reload value, and the extra top bit arms the block. A separate write port sets the window value. A configuration strap can also arm the block. Once armed, only the block's own reset input disarms it. The reset-request output is a one-cycle pulse for a system reset generator, which lies outside this block.

Top module: `winwdg_top`

## Requirements
- R1: After reset the count and the window both read 0x7F, the armed flag reads 0 (with the strap low), and no reset request is raised.
- R2: While armed, each tick lowers the count by one in the following cycle. While not armed, ticks leave the count unchanged.
- R3: While armed, a tick that takes the count from 0x40 to 0x3F raises the reset request in the cycle after that tick, for exactly one cycle.
- R4: A counter write loads bits 6:0 into the count. A write with bit 7 set arms the block. A write that finds the count at or below the window raises no reset request.
- R5: A counter write made while armed, with the current count strictly above the window, raises the reset request for one cycle in the cycle after the write.
- R6: Once the block is armed, no write disarms it. Only the block's reset input does. Raising the strap input arms the block in the next cycle.
- R7: A counter write whose bit 6 is clear raises the reset request in the next cycle if the block is armed after that write.
- R8: A window write loads bits 6:0 as the new window value. When a counter write and a tick occur in the same cycle, the written value is loaded and the tick is ignored.
- R9: While not armed, neither a too-early write nor a write with bit 6 clear and bit 7 clear raises a reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the only way to disarm |
| tick_i | input | 1 | Prescaled count strobe, one cycle per step |
| hw_en_i | input | 1 | Configuration strap that arms the block |
| cnt_we_i | input | 1 | Counter write strobe (refresh) |
| cnt_wdata_i | input | 8 | Bit 7 arms the block; bits 6:0 are the reload value |
| win_we_i | input | 1 | Window write strobe |
| win_wdata_i | input | 7 | New window value |
| count_o | output | 7 | Current count |
| win_o | output | 7 | Current window value |
| en_o | output | 1 | Armed flag |
| rst_req_o | output | 1 | One-cycle reset request pulse |

## Verification
The hardest case to reach is a reset request that depends on earlier state rather than on the current write. The early-refresh fault only applies once the block was armed before the write. The bench therefore arms the block with a first write, lowers the window, and then refreshes a second time, so the same write value hits the check both disarmed and armed. A timeout needs the count exactly at 0x40 when a tick arrives. The bench loads 0x42 and counts the ticks it issues, so the pulse's cycle is known ahead of time. It also checks that the pulse is gone one cycle later.

// File: rtl/winwdg_pkg.sv
package winwdg_pkg;
    // Reason for a reset request in the current cycle, highest priority first.
    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_BADLOAD = 2'd1,
        CAUSE_EARLY   = 2'd2,
        CAUSE_EXPIRE  = 2'd3
    } cause_e;
endpackage

// File: rtl/winwdg_count.sv
module winwdg_count #(
    parameter int CNT_W = 7
) (
    input  logic             en_q,
    input  logic             tick_i,
    input  logic             we_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_d,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] EDGE_VAL = {1'b1, {(CNT_W-1){1'b0}}};

    always_comb begin
        cnt_d    = cnt_q;
        expire_o = 1'b0;
        if (we_i) begin
            cnt_d = wdata_i;
        end else if (en_q && tick_i) begin
            cnt_d    = cnt_q - 1'b1;
            expire_o = (cnt_q == EDGE_VAL);
        end
    end
endmodule

// File: rtl/winwdg_fault.sv
module winwdg_fault
    import winwdg_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             en_q,
    input  logic             en_d,
    input  logic             we_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] win_q,
    input  logic             expire_i,
    output cause_e           cause_o
);
    logic early;
    logic badload;

    always_comb begin
        early   = we_i && en_q && (cnt_q > win_q);
        badload = we_i && en_d && !wdata_i[CNT_W-1];
        if (badload)       cause_o = CAUSE_BADLOAD;
        else if (early)    cause_o = CAUSE_EARLY;
        else if (expire_i) cause_o = CAUSE_EXPIRE;
        else               cause_o = CAUSE_NONE;
    end
endmodule

// File: rtl/winwdg_top.sv
module winwdg_top
    import winwdg_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             hw_en_i,
    input  logic             cnt_we_i,
    input  logic [CNT_W:0]   cnt_wdata_i,
    input  logic             win_we_i,
    input  logic [CNT_W-1:0] win_wdata_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] win_o,
    output logic             en_o,
    output logic             rst_req_o
);
    localparam int               ARM_BIT  = CNT_W;
    localparam logic [CNT_W-1:0] INIT_VAL = {CNT_W{1'b1}};

    typedef struct packed {
        logic             en;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] win;
        logic             req;
    } state_t;

    state_t state_d, state_q;
    logic [CNT_W-1:0] cnt_next;
    logic             expire;
    cause_e           cause;

    winwdg_count #(.CNT_W(CNT_W)) u_count (
        .en_q     (state_q.en),
        .tick_i   (tick_i),
        .we_i     (cnt_we_i),
        .wdata_i  (cnt_wdata_i[CNT_W-1:0]),
        .cnt_q    (state_q.cnt),
        .cnt_d    (cnt_next),
        .expire_o (expire)
    );

    winwdg_fault #(.CNT_W(CNT_W)) u_fault (
        .en_q     (state_q.en),
        .en_d     (state_d.en),
        .we_i     (cnt_we_i),
        .wdata_i  (cnt_wdata_i[CNT_W-1:0]),
        .cnt_q    (state_q.cnt),
        .win_q    (state_q.win),
        .expire_i (expire),
        .cause_o  (cause)
    );

    always_comb begin
        state_d     = state_q;
        // Arming is sticky: only rst_n clears it.
        state_d.en  = state_q.en | hw_en_i | (cnt_we_i & cnt_wdata_i[ARM_BIT]);
        state_d.cnt = cnt_next;
        if (win_we_i) state_d.win = win_wdata_i;
        state_d.req = (cause != CAUSE_NONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.en  <= 1'b0;
            state_q.cnt <= INIT_VAL;
            state_q.win <= INIT_VAL;
            state_q.req <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign count_o   = state_q.cnt;
    assign win_o     = state_q.win;
    assign en_o      = state_q.en;
    assign rst_req_o = state_q.req;
endmodule

// File: rtl/winwdg_chk.sv
module winwdg_chk #(
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_i,
    input logic             hw_en_i,
    input logic             cnt_we_i,
    input logic [CNT_W:0]   cnt_wdata_i,
    input logic             win_we_i,
    input logic [CNT_W-1:0] win_wdata_i,
    input logic [CNT_W-1:0] count_o,
    input logic [CNT_W-1:0] win_o,
    input logic             en_o,
    input logic             rst_req_o
);
    localparam logic [CNT_W-1:0] EDGE_VAL = {1'b1, {(CNT_W-1){1'b0}}};

    // R2
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o && tick_i && !cnt_we_i) |=> (count_o == CNT_W'($past(count_o) - 1'b1)));

    // R2
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_o && !cnt_we_i) |=> $stable(count_o));

    // R3
    expire_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o && tick_i && !cnt_we_i && count_o == EDGE_VAL) |=> rst_req_o);

    // R4
    load_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we_i |=> (count_o == $past(cnt_wdata_i[CNT_W-1:0])));

    // R5
    early_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_we_i && en_o && count_o > win_o) |=> rst_req_o);

    // R6
    arm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_o |=> en_o);

    // R7
    badload_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_we_i && (en_o || cnt_wdata_i[CNT_W]) && !cnt_wdata_i[CNT_W-1]) |=> rst_req_o);

    // R8
    win_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_we_i |=> (win_o == $past(win_wdata_i)));

    // R9
    quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_o && !hw_en_i && !(cnt_we_i && cnt_wdata_i[CNT_W])) |=> !rst_req_o);
endmodule

bind winwdg_top winwdg_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .hw_en_i     (hw_en_i),
    .cnt_we_i    (cnt_we_i),
    .cnt_wdata_i (cnt_wdata_i),
    .win_we_i    (win_we_i),
    .win_wdata_i (win_wdata_i),
    .count_o     (count_o),
    .win_o       (win_o),
    .en_o        (en_o),
    .rst_req_o   (rst_req_o)
);

// File: tb/winwdg_top_test.sv
module winwdg_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       hw_en_i = 1'b0;
    logic       cnt_we_i = 1'b0;
    logic [7:0] cnt_wdata_i = 8'h00;
    logic       win_we_i = 1'b0;
    logic [6:0] win_wdata_i = 7'h00;
    logic [6:0] count_o;
    logic [6:0] win_o;
    logic       en_o;
    logic       rst_req_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    winwdg_top #(.CNT_W(7)) uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .hw_en_i(hw_en_i),
        .cnt_we_i(cnt_we_i), .cnt_wdata_i(cnt_wdata_i),
        .win_we_i(win_we_i), .win_wdata_i(win_wdata_i),
        .count_o(count_o), .win_o(win_o), .en_o(en_o), .rst_req_o(rst_req_o)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=<20000", cycles);
            finish_run();
        end
    end

    // Inputs change at negedge; one step spans one posedge; outputs read after it.
    task automatic step();
        @(negedge clk);
        tick_i = 1'b0; cnt_we_i = 1'b0; win_we_i = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick_i = 1'b0; cnt_we_i = 1'b0; win_we_i = 1'b0; hw_en_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr_cnt(logic [7:0] v);
        cnt_wdata_i = v; cnt_we_i = 1'b1;
        step();
    endtask

    task automatic wr_win(logic [6:0] v);
        win_wdata_i = v; win_we_i = 1'b1;
        step();
    endtask

    task automatic tick();
        tick_i = 1'b1;
        step();
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 count", count_o, 7'h7F);
        check("R1 window", win_o, 7'h7F);
        check("R1 armed", en_o, 0);
        check("R1 req", rst_req_o, 0);
    endtask

    task automatic t_idle_ticks();
        do_reset();
        tick(); tick();
        check("R2 idle hold", count_o, 7'h7F);
        check("R9 idle req", rst_req_o, 0);
    endtask

    task automatic t_timeout();
        do_reset();
        wr_cnt(8'hC2);
        check("R4 arm", en_o, 1);
        check("R4 load", count_o, 7'h42);
        check("R4 no req", rst_req_o, 0);
        tick();
        check("R2 step", count_o, 7'h41);
        tick();
        check("R3 before edge", rst_req_o, 0);
        tick();
        check("R3 count", count_o, 7'h3F);
        check("R3 req", rst_req_o, 1);
        step();
        check("R3 one cycle", rst_req_o, 0);
        tick();
        check("R3 no repeat", rst_req_o, 0);
    endtask

    task automatic t_refresh_ok();
        do_reset();
        wr_win(7'h50);
        check("R8 window", win_o, 7'h50);
        wr_cnt(8'hD0);
        wr_cnt(8'hFF);
        check("R4 in-window refresh", rst_req_o, 0);
        check("R4 reload", count_o, 7'h7F);
    endtask

    task automatic t_early();
        do_reset();
        wr_cnt(8'hFF);
        check("R5 first write no req", rst_req_o, 0);
        wr_win(7'h50);
        wr_cnt(8'hFF);
        check("R5 early req", rst_req_o, 1);
        step();
        check("R5 one cycle", rst_req_o, 0);
    endtask

    task automatic t_badload();
        do_reset();
        wr_cnt(8'hBF);
        check("R7 req", rst_req_o, 1);
        check("R7 count", count_o, 7'h3F);
        do_reset();
        wr_cnt(8'h3F);
        check("R9 disarmed bad value", rst_req_o, 0);
        check("R9 still disarmed", en_o, 0);
        wr_win(7'h10);
        wr_cnt(8'h7F);
        check("R9 disarmed early", rst_req_o, 0);
    endtask

    task automatic t_sticky();
        do_reset();
        wr_cnt(8'hFF);
        wr_cnt(8'h7F);
        check("R6 write keeps armed", en_o, 1);
        check("R6 no req", rst_req_o, 0);
        do_reset();
        check("R6 reset disarms", en_o, 0);
        hw_en_i = 1'b1;
        step();
        hw_en_i = 1'b0;
        check("R6 strap arms", en_o, 1);
        step();
        check("R6 strap sticky", en_o, 1);
    endtask

    task automatic t_priority();
        do_reset();
        wr_cnt(8'hD0);
        cnt_wdata_i = 8'hC5; cnt_we_i = 1'b1; tick_i = 1'b1;
        step();
        check("R8 write beats tick", count_o, 7'h45);
        check("R8 no req", rst_req_o, 0);
    endtask

    initial begin
        t_reset();
        t_idle_ticks();
        t_timeout();
        t_refresh_ok();
        t_early();
        t_badload();
        t_sticky();
        t_priority();
        finish_run();
    end
endmodule